// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the two low-order word-address bits for a memory burst of up to four words. When either of two independent address strobes is seen at a rising clock edge, it captures a 2-bit start address and resets its internal beat index to zero. Each later edge with the advance input high moves the beat index forward by one. The index wraps from three back to zero, so a burst longer than four beats repeats the same four addresses.

The output address comes from the captured start and the beat index. The rule depends on a static order select. In interleaved order the address is the start XOR the beat index. In linear order it is the start plus the beat index, modulo four. A flag marks the fourth beat of the group. Upper address bits, storage and data paths sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `burst_addr` is 00 and `last_beat` is 0.
- R2: When `load_cpu` is 1 at a rising edge, `burst_addr` equals the `start_addr` sampled at that edge after the edge, and the beat index is 0.
- R3: When `load_ctl` is 1 at a rising edge, the start address is captured in the same way as for `load_cpu`.
- R4: With both strobes low, an edge with `advance` at 1 increments the beat index by one. An edge with `advance` at 0 leaves the beat index and the address unchanged.
- R5: With `order_sel` = 1 (interleaved), `burst_addr` = start XOR beat. A start of 01 gives 01, 00, 11, 10.
- R6: With `order_sel` = 0 (linear), `burst_addr` = (start + beat) mod 4. A start of 10 gives 10, 11, 00, 01.
- R7: An advance taken on the fourth beat returns `burst_addr` to the start address.
- R8: A strobe at the same edge as `advance` wins. The beat index restarts at 0 and the new start is used.
- R9: `last_beat` is 1 exactly when the beat index is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_cpu | input | 1 | Processor-side address strobe, active high |
| load_ctl | input | 1 | Controller-side address strobe, active high |
| advance | input | 1 | Step to the next beat, active high |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| start_addr | input | 2 | Low address bits captured on a strobe |
| burst_addr | output | 2 | Current low address bits of the burst |
| last_beat | output | 1 | High while the beat index is 3 |

## Verification
The bound checker runs on every cycle. It checks that either strobe loads the start address and clears the beat index, even when advance is also high. It checks that advance without a strobe steps the beat index by one and that idle cycles hold it. It checks that an advance on the last beat returns to the start address and that a strobe always clears the last-beat flag.

The exact address sequences for the two orders need the bench's scenarios, because they rely on values from more than one cycle earlier. These include 01 interleaved and 10 linear, the reset state, and agreement with an independent model under random strobes, advances and order changes.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } order_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [BEAT_W-1:0] start_in,
  output logic [BEAT_W-1:0] start_q,
  output logic [BEAT_W-1:0] beat_q
);
  logic [BEAT_W-1:0] start_d, beat_d;
  logic              start_en, beat_en;

  always_comb begin
    start_en = load;
    beat_en  = load | step;
    start_d  = start_in;
    if (load) beat_d = '0;
    else      beat_d = beat_q + BEAT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else begin
      if (start_en) start_q <= start_d;
      if (beat_en)  beat_q  <= beat_d;
    end
  end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  order_e            order,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] addr,
  output logic              last
);
  localparam logic [BEAT_W-1:0] BEAT_MAX = {BEAT_W{1'b1}};

  logic [BEAT_W-1:0] addr_ilv, addr_lin;

  genvar gi;
  generate
    for (gi = 0; gi < BEAT_W; gi++) begin : g_xor
      assign addr_ilv[gi] = start[gi] ^ beat[gi];
    end
  endgenerate

  assign addr_lin = start + beat;

  always_comb begin
    case (order)
      ORDER_INTERLEAVED: addr = addr_ilv;
      default:           addr = addr_lin;
    endcase
    last = (beat == BEAT_MAX);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int BEAT_W    = 2,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_cpu,
  input  logic              load_ctl,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [BEAT_W-1:0] start_addr,
  output logic [BEAT_W-1:0] burst_addr,
  output logic              last_beat
);
  logic              rst_sync_n;
  logic              load_any;
  logic [BEAT_W-1:0] start_q, beat_q;

  assign load_any = load_cpu | load_ctl;

  burst_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load_any),
    .step     (advance),
    .start_in (start_addr),
    .start_q  (start_q),
    .beat_q   (beat_q)
  );

  burst_addr_map #(.BEAT_W(BEAT_W)) u_map (
    .order (order_e'(order_sel)),
    .start (start_q),
    .beat  (beat_q),
    .addr  (burst_addr),
    .last  (last_beat)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              load_cpu,
  input logic              load_ctl,
  input logic              advance,
  input logic [BEAT_W-1:0] start_addr,
  input logic [BEAT_W-1:0] start_q,
  input logic [BEAT_W-1:0] beat_q,
  input logic [BEAT_W-1:0] burst_addr,
  input logic              last_beat
);
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_cpu || load_ctl) |=> (start_q == $past(start_addr)) && (beat_q == '0));

  // R8
  load_priority_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((load_cpu || load_ctl) && advance) |=> (beat_q == '0));

  // R4
  step_once_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_cpu && !load_ctl && advance) |=> (beat_q == BEAT_W'($past(beat_q) + 1'b1)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_cpu && !load_ctl && !advance) |=> ($stable(beat_q) && $stable(start_q)));

  // R7
  wrap_start_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (last_beat && advance && !load_cpu && !load_ctl) |=> (burst_addr == start_q));

  // R9
  load_clears_last_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_cpu || load_ctl) |=> !last_beat);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.BEAT_W(BEAT_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .load_cpu   (load_cpu),
  .load_ctl   (load_ctl),
  .advance    (advance),
  .start_addr (start_addr),
  .start_q    (start_q),
  .beat_q     (beat_q),
  .burst_addr (burst_addr),
  .last_beat  (last_beat)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_cpu, load_ctl, advance, order_sel;
  logic [1:0] start_addr;
  logic [1:0] burst_addr;
  logic       last_beat;

  int checks = 0;
  int errors = 0;
  logic       done = 1'b0;
  logic [1:0] m_start = 2'b00;
  logic [1:0] m_beat  = 2'b00;

  always #2.5 clk = ~clk;

  burst_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .load_cpu(load_cpu), .load_ctl(load_ctl),
    .advance(advance), .order_sel(order_sel), .start_addr(start_addr),
    .burst_addr(burst_addr), .last_beat(last_beat)
  );

  function automatic logic [1:0] exp_addr(input logic [1:0] s, input logic [1:0] b, input logic ilv);
    return ilv ? (s ^ b) : 2'(s + b);
  endfunction

  task automatic check(input string tag, input logic [1:0] exp_a, input logic exp_l);
    checks++;
    if (burst_addr !== exp_a || last_beat !== exp_l) begin
      errors++;
      $display("FAIL %s: addr=%b last=%b expected addr=%b last=%b",
               tag, burst_addr, last_beat, exp_a, exp_l);
    end
  endtask

  task automatic step(input string tag, input logic la, input logic lb,
                      input logic adv, input logic ord, input logic [1:0] sa);
    @(negedge clk);
    load_cpu = la; load_ctl = lb; advance = adv; order_sel = ord; start_addr = sa;
    @(posedge clk);
    if (la || lb) begin m_start = sa; m_beat = 2'b00; end
    else if (adv) m_beat = 2'(m_beat + 1);
    #1;
    check(tag, exp_addr(m_start, m_beat, ord), m_beat == 2'd3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; load_cpu = 0; load_ctl = 0; advance = 0; order_sel = 0; start_addr = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", 2'b00, 1'b0);

    // R5 interleaved order from 01 through processor strobe (R2)
    step("R2 load_cpu interleaved", 1, 0, 0, 1, 2'b01);
    step("R5 beat1", 0, 0, 1, 1, 2'b00);
    step("R5 beat2", 0, 0, 1, 1, 2'b00);
    step("R5 beat3 R9 last", 0, 0, 1, 1, 2'b00);
    step("R7 wrap interleaved", 0, 0, 1, 1, 2'b00);

    // R6 linear order from 10 through controller strobe (R3)
    step("R3 load_ctl linear", 0, 1, 0, 0, 2'b10);
    step("R6 beat1", 0, 0, 1, 0, 2'b00);
    step("R4 hold without advance", 0, 0, 0, 0, 2'b01);
    step("R6 beat2", 0, 0, 1, 0, 2'b00);
    step("R6 beat3 R9 last", 0, 0, 1, 0, 2'b00);
    step("R4 hold on last beat", 0, 0, 0, 0, 2'b00);
    step("R7 wrap linear", 0, 0, 1, 0, 2'b00);

    // R8 strobe with advance restarts at beat 0
    step("R8 priority setup", 0, 0, 1, 0, 2'b00);
    step("R8 load with advance", 1, 0, 1, 0, 2'b11);
    step("R8 both strobes with advance", 1, 1, 1, 1, 2'b10);

    // random mix checked against the model
    for (int i = 0; i < 400; i++) begin
      logic la, lb, adv, ord;
      logic [1:0] sa;
      la  = ($urandom % 6) == 0;
      lb  = ($urandom % 6) == 0;
      adv = ($urandom % 3) != 0;
      ord = ($urandom % 8) == 0 ? ~order_sel : order_sel;
      sa  = 2'($urandom);
      if (la)       step("R2 random load_cpu", la, lb, adv, ord, sa);
      else if (lb)  step("R3 random load_ctl", la, lb, adv, ord, sa);
      else if (adv) step(ord ? "R5 random interleaved step" : "R6 random linear step", la, lb, adv, ord, sa);
      else          step("R4 random hold", la, lb, adv, ord, sa);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule